// File: doc/BRIEF.md
# Six-Input Rotating Priority Arbiter

The block selects one winner among six request lines. The winner is the request that stands highest in an order picked by a two-bit order select. Line 0 always ranks first and line 5 always ranks last. The four middle lines (1 to 4) are placed in a cyclic order that the select value chooses. The grant is combinational: it follows the current requests and the current select with no register in between. The block also gives the grant as a binary index and raises an any-request flag whenever at least one request is active.

When the rotate bit is set, a service strobe updates the select on the clock edge where it is asserted. The update depends on which middle line was granted, and it moves that line to the last of the middle ranks. Software can load the select and the rotate bit at any time, and the select it holds is always visible on an output.

A parameter picks a four-input variant, used for a group that has only lines 1 to 4. In that variant lines 0 and 5 are ignored. Instances can be wired into a two-level tree: each group arbiter's any-request output feeds one line of a final arbiter, and that final arbiter has its own select and rotate bit.

Top module: `rot_prio_arb6`

## Requirements
- R1: The middle lines are ranked as follows, with each select value written as two bits. Select 00 ranks 1,2,3,4. Select 01 ranks 2,3,4,1. Select 10 ranks 3,4,1,2. Select 11 ranks 4,1,2,3. The granted line is the active request with the best rank.
- R2: In the six-input variant, an active line 0 always wins. Line 5 wins only when no other line is active.
- R3: With no active request, `any_req` is 0, `grant` is all zero and `grant_idx` is 0.
- R4: Reset sets the select to 00 and the rotate bit to 0.
- R5: With the rotate bit at 0, the select holds its value across service strobes.
- R6: With the rotate bit at 1, a service strobe on a grant of line n (n in 1 to 4) sets the select to n modulo 4. Line 1 gives 01, line 2 gives 10, line 3 gives 11 and line 4 gives 00.
- R7: With the rotate bit at 1, a service strobe on a grant of line 0 or line 5 leaves the select unchanged.
- R8: When `cfg_we` is high, the select and the rotate bit take `cfg_sel` and `cfg_rot` on that edge, even if an automatic update would happen in the same cycle.
- R9: With `SIX_WIDE`=0, lines 0 and 5 never win and never count towards `any_req`. Lines 1 to 4 follow R1 and R6.
- R10: `grant` is one-hot or zero, and when it is non-zero its set bit sits at position `grant_idx`. It reflects the requests in the same cycle.
- R11: A service strobe while no request is active leaves the select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 6 | Request lines, bit n is line n |
| cfg_we | input | 1 | Load select and rotate bit |
| cfg_sel | input | 2 | Select value to load |
| cfg_rot | input | 1 | Rotate bit to load |
| svc | input | 1 | Service strobe for the current grant |
| grant | output | 6 | One-hot grant |
| grant_idx | output | 3 | Index of the granted line |
| any_req | output | 1 | At least one counted request active |
| sel_o | output | 2 | Live select value |

## Verification
Every one of the 64 request patterns is applied under each of the four select values. This separates the four rank orders and shows that lines 0 and 5 keep the same place in each of them. Patterns with a single request check the rotate rule line by line, each with the rotate bit both clear and set. Strobes are also given with an empty request set, and a write is made in the same cycle as a strobe, which checks which of the two updates wins. A long random stream is run on both variants side by side, each compared against a reference model that builds its rank list explicitly.

// File: rtl/arb6_pkg.sv
package arb6_pkg;
    localparam int NREQ = 6;
    localparam int IDXW = $clog2(NREQ);
    localparam int SELW = 2;
    localparam int NMID = NREQ - 2;

    typedef struct packed {
        logic [SELW-1:0] sel;
        logic            rot;
    } arb_state_t;
endpackage

// File: rtl/arb6_order.sv
module arb6_order
    import arb6_pkg::*;
(
    input  logic [SELW-1:0]      sel,
    output logic [NREQ*IDXW-1:0] order_flat
);
    assign order_flat[IDXW-1:0] = IDXW'(0);
    assign order_flat[(NREQ-1)*IDXW +: IDXW] = IDXW'(NREQ - 1);

    for (genvar k = 1; k <= NMID; k++) begin : g_mid
        logic [SELW-1:0] slot;
        assign slot = sel + SELW'(k - 1);
        assign order_flat[k*IDXW +: IDXW] = IDXW'(slot) + IDXW'(1);
    end
endmodule

// File: rtl/arb6_pick.sv
module arb6_pick
    import arb6_pkg::*;
(
    input  logic [NREQ-1:0]      req,
    input  logic [NREQ*IDXW-1:0] order_flat,
    output logic [NREQ-1:0]      grant,
    output logic [IDXW-1:0]      idx,
    output logic                 any
);
    always_comb begin
        idx = '0;
        for (int r = NREQ - 1; r >= 0; r--) begin
            if (req[order_flat[r*IDXW +: IDXW]]) begin
                idx = order_flat[r*IDXW +: IDXW];
            end
        end
        any   = |req;
        grant = any ? (NREQ'(1) << idx) : '0;
    end
endmodule

// File: rtl/arb6_rotate.sv
module arb6_rotate
    import arb6_pkg::*;
(
    input  logic [IDXW-1:0] idx,
    output logic [SELW-1:0] sel_next,
    output logic            moves
);
    always_comb begin
        moves    = (idx >= IDXW'(1)) && (idx <= IDXW'(NMID));
        sel_next = idx[SELW-1:0];
    end
endmodule

// File: rtl/rot_prio_arb6.sv
module rot_prio_arb6
    import arb6_pkg::*;
#(
    parameter bit SIX_WIDE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [5:0]      req,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic            cfg_rot,
    input  logic            svc,
    output logic [5:0]      grant,
    output logic [2:0]      grant_idx,
    output logic            any_req,
    output logic [1:0]      sel_o
);
    localparam logic [NREQ-1:0] EDGE_BITS = NREQ'(1) | (NREQ'(1) << (NREQ - 1));
    localparam logic [NREQ-1:0] REQ_MASK  = SIX_WIDE ? '1 : ~EDGE_BITS;

    arb_state_t st_d, st_q;

    logic [NREQ-1:0]      req_eff;
    logic [NREQ*IDXW-1:0] order_flat;
    logic [SELW-1:0]      sel_next;
    logic                 moves;
    logic                 rot_live;

    assign req_eff = req & REQ_MASK;

    arb6_order u_order (
        .sel        (st_q.sel),
        .order_flat (order_flat)
    );

    arb6_pick u_pick (
        .req        (req_eff),
        .order_flat (order_flat),
        .grant      (grant),
        .idx        (grant_idx),
        .any        (any_req)
    );

    arb6_rotate u_rot (
        .idx      (grant_idx),
        .sel_next (sel_next),
        .moves    (moves)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.sel = cfg_sel;
            st_d.rot = cfg_rot;
        end else if (svc && any_req && st_q.rot && moves) begin
            st_d.sel = sel_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sel: '0, rot: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o    = st_q.sel;
    assign rot_live = st_q.rot;
endmodule

// File: rtl/arb6_chk.sv
module arb6_chk #(
    parameter bit SIX_WIDE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] req,
    input logic       cfg_we,
    input logic [1:0] cfg_sel,
    input logic       cfg_rot,
    input logic       svc,
    input logic [5:0] grant,
    input logic [2:0] grant_idx,
    input logic       any_req,
    input logic [1:0] sel_o,
    input logic       rot_live
);
    // R3
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |-> (grant == 6'b0));

    // R10
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10
    idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> grant[grant_idx]);

    // R2
    top_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SIX_WIDE && req[0]) |-> grant[0]);

    // R9
    edge_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !SIX_WIDE |-> (!grant[0] && !grant[5]));

    // R5
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !rot_live) |=> $stable(sel_o));

    // R6
    rot_line1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && rot_live && svc && grant[1]) |=> (sel_o == 2'b01));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (sel_o == $past(cfg_sel)));
endmodule

bind rot_prio_arb6 arb6_chk #(.SIX_WIDE(SIX_WIDE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_rot   (cfg_rot),
    .svc       (svc),
    .grant     (grant),
    .grant_idx (grant_idx),
    .any_req   (any_req),
    .sel_o     (sel_o),
    .rot_live  (rot_live)
);

// File: tb/sim_rot_prio_arb6.sv
module sim_rot_prio_arb6;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] req = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic       cfg_rot = 1'b0;
    logic       svc = 1'b0;

    logic [5:0] g0, g1;
    logic [2:0] i0, i1;
    logic       a0, a1;
    logic [1:0] s0, s1;

    int n_chk = 0;
    int n_bad = 0;
    int m_sel[2];
    int m_rot[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    rot_prio_arb6 #(.SIX_WIDE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_rot(cfg_rot), .svc(svc), .grant(g0), .grant_idx(i0), .any_req(a0), .sel_o(s0));

    rot_prio_arb6 #(.SIX_WIDE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_rot(cfg_rot), .svc(svc), .grant(g1), .grant_idx(i1), .any_req(a1), .sel_o(s1));

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference: builds the rank list explicitly, returns winner or -1
    function automatic int ref_pick(int sel, bit six, logic [5:0] r);
        int q[$];
        if (six) q.push_back(0);
        for (int k = 0; k < 4; k++) q.push_back(1 + ((sel + k) % 4));
        if (six) q.push_back(5);
        foreach (q[j]) if (r[q[j]]) return q[j];
        return -1;
    endfunction

    task automatic compare_one(int u, string tag, logic [5:0] g, logic [2:0] ix,
                               logic a, logic [1:0] s);
        int w;
        w = ref_pick(m_sel[u], (u == 0), req);
        check(tag, "sel", int'(s), m_sel[u]);
        check(tag, "any", int'(a), (w >= 0) ? 1 : 0);
        check(tag, "grant", int'(g), (w >= 0) ? (1 << w) : 0);
        check(tag, "idx", int'(ix), (w >= 0) ? w : 0);
    endtask

    task automatic cyc(string tag, logic [5:0] r, logic we, logic [1:0] s,
                       logic rt, logic sv);
        int nsel[2];
        int nrot[2];
        @(negedge clk);
        req = r; cfg_we = we; cfg_sel = s; cfg_rot = rt; svc = sv;
        #1;
        compare_one(0, tag, g0, i0, a0, s0);
        compare_one(1, "R9", g1, i1, a1, s1);
        for (int u = 0; u < 2; u++) begin
            int w;
            w = ref_pick(m_sel[u], (u == 0), r);
            nsel[u] = m_sel[u];
            nrot[u] = m_rot[u];
            if (we) begin
                nsel[u] = int'(s);
                nrot[u] = int'(rt);
            end else if (sv && m_rot[u] == 1 && w >= 1 && w <= 4) begin
                nsel[u] = w % 4;
            end
        end
        @(posedge clk);
        for (int u = 0; u < 2; u++) begin
            m_sel[u] = nsel[u];
            m_rot[u] = nrot[u];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_sel[0] = 0; m_sel[1] = 0; m_rot[0] = 0; m_rot[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R4: state after reset
        check("R4", "sel after reset", int'(s0), 0);
        check("R4", "sel after reset", int'(s1), 0);
        // R3: nothing requested
        cyc("R3", 6'b000000, 0, 2'b00, 0, 0);
        cyc("R3", 6'b000000, 0, 2'b00, 0, 1);
        // R1 and R2: exhaustive patterns under every select
        for (int s = 0; s < 4; s++) begin
            cyc("R1", 6'b000000, 1, 2'(s), 0, 0);
            for (int r = 0; r < 64; r++) begin
                cyc((r[0] || r == 32) ? "R2" : "R1", 6'(r), 0, 2'(s), 0, r[2]);
            end
        end
        // R5: rotate off, strobes do not move select
        cyc("R5", 6'b000000, 1, 2'b10, 0, 0);
        for (int n = 0; n < 6; n++) cyc("R5", 6'(1 << n), 0, 2'b00, 0, 1);
        // R6: rotate on, each middle line
        cyc("R6", 6'b000000, 1, 2'b00, 1, 0);
        for (int n = 1; n <= 4; n++) begin
            cyc("R6", 6'(1 << n), 0, 2'b00, 0, 1);
            cyc("R6", 6'b011110, 0, 2'b00, 0, 0);
        end
        cyc("R6", 6'b011110, 0, 2'b00, 0, 1);
        cyc("R6", 6'b011110, 0, 2'b00, 0, 1);
        // R7: line 0 and line 5 leave select alone
        cyc("R7", 6'b000001, 0, 2'b00, 0, 1);
        cyc("R7", 6'b100000, 0, 2'b00, 0, 1);
        cyc("R7", 6'b100001, 0, 2'b00, 0, 1);
        cyc("R7", 6'b000000, 0, 2'b00, 0, 0);
        // R11: strobe with nothing requested
        cyc("R11", 6'b000000, 0, 2'b00, 0, 1);
        cyc("R11", 6'b000000, 0, 2'b00, 0, 0);
        // R8: write beats same-cycle rotation
        cyc("R8", 6'b000100, 1, 2'b11, 1, 1);
        cyc("R8", 6'b000100, 0, 2'b00, 0, 0);
        cyc("R8", 6'b001000, 1, 2'b01, 0, 1);
        cyc("R8", 6'b001000, 0, 2'b00, 0, 1);
        // R10: random traffic, both variants compared every cycle
        for (int k = 0; k < 2000; k++) begin
            logic [5:0] rr;
            logic we;
            rr = 6'($urandom);
            we = ($urandom % 16) == 0;
            cyc("R10", rr, we, 2'($urandom), 1'($urandom % 4 != 0), 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule